// File: doc/BRIEF.md
# SM3 Compression Round Unit

This block performs one step of the SM3 hash compression on a 128-bit working state. The state is split into four 32-bit lanes, d0 to d3. Two more 128-bit operands, n and m, take part in the step. A 2-bit lane index picks one word of m, and a 2-bit operation code picks one of four round variants. The variants differ in their Boolean mixing function and in their rotation amounts. A second kind of operation computes the SS1 helper value from lane 3 of three 128-bit sources.

The operation can be given as decoded fields or as a raw 32-bit instruction word, which the block decodes itself. A raw word that matches neither the round form nor the SS1 form is flagged as illegal. In that case the state passes through unchanged.

The result is registered. It is offered on a valid/ready handshake and held until the consumer takes it, so a new operation can be accepted in the same cycle that the previous result is drained.

Top module: `sm3_round_unit`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. An input accepted at a clock edge (`in_valid` and `in_ready` both high) gives `out_valid` high and its result on `result` right after that edge.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `result` stays unchanged. When `out_valid` and `out_ready` are both high and no new input is accepted, `out_valid` goes low after the edge. A synchronous `rst` clears `out_valid`.
- R3: For a round, the operation code selects the Boolean function of lanes d3, d2, d1. Codes 0 and 2 give the three-way XOR. Code 1 gives the bitwise majority. Code 3 gives choose, which is (d3 AND d2) OR (NOT d3 AND d1).
- R4: The working sum is the Boolean value plus d0 plus the m lane picked by the index. For codes 0 and 1 the final word is this sum plus (n lane 3 XOR d3 rotated right by 20), and the new d1 is d2 rotated right by 23.
- R5: For codes 2 and 3, n lane 3 is first added to the working sum (call the total s). The final word is s XOR (s rotated left by 9) XOR (s rotated left by 17), and the new d1 is d2 rotated right by 13.
- R6: In every round variant the new d0 is the old d1, the new d2 is the old d3, and the new d3 is the final word.
- R7: SS1 output lane 3 is ((n3 rotated right by 20) + m3 + a3) rotated right by 25. Here n3, m3 and a3 are lane 3 of `opn_n`, `opn_m` and `opn_a`. Lanes 0 to 2 of the output are zero.
- R8: With `use_raw` low, `do_ss1` selects SS1 (1) or a round (0), `op_code` and `lane_sel` give the variant and index, `insn` has no effect, and `illegal` stays low.
- R9: With `use_raw` high, a word whose value AND 0xFFE0C000 equals 0xCE408000 is a round. Its operation code is bits 11:10 and its lane index is bits 13:12.
- R10: With `use_raw` high, a word whose value AND 0xFFE08000 equals 0xCE400000 is an SS1 operation, whatever its other bits.
- R11: With `use_raw` high and a word matching neither form, `illegal` is high with the result, and `result` equals the `state_in` that was accepted.
- R12: Lane k of every 128-bit operand and of the result occupies bits 32k+31 to 32k. All additions are modulo 2^32 with no carry between lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| use_raw | input | 1 | 1: decode `insn`; 0: use the decoded fields |
| insn | input | 32 | Raw instruction word |
| do_ss1 | input | 1 | Decoded select: 1 SS1, 0 round |
| op_code | input | 2 | Decoded round variant |
| lane_sel | input | 2 | Decoded index of the m lane |
| state_in | input | 128 | Working state d3..d0 |
| opn_n | input | 128 | Operand n (SS1 source 1) |
| opn_m | input | 128 | Operand m (SS1 source 2) |
| opn_a | input | 128 | SS1 source 3 |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 128 | Registered result |
| illegal | output | 1 | Raw word matched no form (with result) |

## Verification
Two things can happen at the same clock edge: a result is drained and a new operation is accepted. The bench provokes this by holding `in_valid` and `out_ready` high over consecutive operations. It judges the case by whether each result appears for exactly one cycle and matches an independent model of the round and SS1 arithmetic. It also checks the opposite case, where `out_ready` is held low: a second offer must then be refused, and the pending result must stay untouched until the consumer takes it.

// File: rtl/sm3_round_unit.sv
module sm3_round_unit (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         use_raw,
  input  logic [31:0]  insn,
  input  logic         do_ss1,
  input  logic [1:0]   op_code,
  input  logic [1:0]   lane_sel,
  input  logic [127:0] state_in,
  input  logic [127:0] opn_n,
  input  logic [127:0] opn_m,
  input  logic [127:0] opn_a,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [127:0] result,
  output logic         illegal
);
  localparam int LW = 32;
  localparam logic [31:0] RND_MASK = 32'hFFE0C000;
  localparam logic [31:0] RND_PAT  = 32'hCE408000;
  localparam logic [31:0] SS1_MASK = 32'hFFE08000;
  localparam logic [31:0] SS1_PAT  = 32'hCE400000;

  function automatic logic [LW-1:0] rotr(input logic [LW-1:0] x, input int s);
    return (x >> s) | (x << (LW - s));
  endfunction

  function automatic logic [LW-1:0] rotl(input logic [LW-1:0] x, input int s);
    return (x << s) | (x >> (LW - s));
  endfunction

  logic rnd_hit, ss1_hit, bad, sel_ss1, acc;
  logic [1:0] op, lane;

  assign rnd_hit = (insn & RND_MASK) == RND_PAT;
  assign ss1_hit = (insn & SS1_MASK) == SS1_PAT;
  assign bad     = use_raw && !rnd_hit && !ss1_hit;
  assign sel_ss1 = use_raw ? ss1_hit : do_ss1;
  assign op      = use_raw ? insn[11:10] : op_code;
  assign lane    = use_raw ? insn[13:12] : lane_sel;

  logic [LW-1:0] d0, d1, d2, d3, n3, msel;
  assign d0   = state_in[31:0];
  assign d1   = state_in[63:32];
  assign d2   = state_in[95:64];
  assign d3   = state_in[127:96];
  assign n3   = opn_n[127:96];
  assign msel = opn_m[lane*LW +: LW];

  logic [LW-1:0] bfn;
  always_comb begin
    case (op)
      2'd1:    bfn = (d3 & d2) | (d3 & d1) | (d2 & d1);
      2'd3:    bfn = (d3 & d2) | (~d3 & d1);
      default: bfn = d3 ^ d2 ^ d1;
    endcase
  end

  logic [LW-1:0] wsum, tt1, tt2s, tt2, fin, nd1, ss1;
  assign wsum = bfn + d0 + msel;
  assign tt1  = wsum + (n3 ^ rotr(d3, 20));
  assign tt2s = wsum + n3;
  assign tt2  = tt2s ^ rotl(tt2s, 9) ^ rotl(tt2s, 17);
  assign fin  = op[1] ? tt2 : tt1;
  assign nd1  = op[1] ? rotr(d2, 13) : rotr(d2, 23);
  assign ss1  = rotr(rotr(n3, 20) + opn_m[127:96] + opn_a[127:96], 25);

  logic [127:0] nxt;
  always_comb begin
    if (bad)          nxt = state_in;
    else if (sel_ss1) nxt = {ss1, 96'd0};
    else              nxt = {fin, d3, nd1, d1};
  end

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else if (acc) begin
      out_valid <= 1'b1;
      result    <= nxt;
      illegal   <= bad;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1
  accept_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);

  // R2
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(result)));

  // R2
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R11
  illegal_passes_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && bad) |=> (illegal && result == $past(state_in)));

  // R6
  lane_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !bad && !sel_ss1) |=>
      (result[31:0] == $past(state_in[63:32]) &&
       result[95:64] == $past(state_in[127:96]) && !illegal));

  // R7
  ss1_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !bad && sel_ss1) |=> (result[95:0] == 96'd0));
endmodule

// File: tb/sm3_round_unit_tb.sv
`timescale 1ns/1ps
module sm3_round_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, use_raw = 1'b0, do_ss1 = 1'b0, out_ready = 1'b1;
  logic [31:0] insn = '0;
  logic [1:0] op_code = '0, lane_sel = '0;
  logic [127:0] state_in = '0, opn_n = '0, opn_m = '0, opn_a = '0;
  logic in_ready, out_valid, illegal;
  logic [127:0] result;

  always #5 clk = ~clk;

  sm3_round_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .use_raw(use_raw), .insn(insn), .do_ss1(do_ss1), .op_code(op_code),
    .lane_sel(lane_sel), .state_in(state_in), .opn_n(opn_n), .opn_m(opn_m),
    .opn_a(opn_a), .out_valid(out_valid), .out_ready(out_ready),
    .result(result), .illegal(illegal));

  int checks = 0, errors = 0;
  bit done = 0;

  // {use_raw, do_ss1, op, lane, insn, kind}; kind 0 round, 1 SS1, 2 illegal
  localparam int NV = 15;
  localparam logic [39:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'd0, 2'd0, 32'h00000000, 2'd0},
    {1'b0, 1'b0, 2'd1, 2'd1, 32'h00000000, 2'd0},
    {1'b0, 1'b0, 2'd2, 2'd2, 32'h00000000, 2'd0},
    {1'b0, 1'b0, 2'd3, 2'd3, 32'h00000000, 2'd0},
    {1'b0, 1'b1, 2'd0, 2'd0, 32'h00000000, 2'd1},
    {1'b0, 1'b0, 2'd1, 2'd0, 32'hFFFFFFFF, 2'd0},
    {1'b1, 1'b0, 2'd1, 2'd2, 32'hCE43A4A7, 2'd0},
    {1'b1, 1'b0, 2'd3, 2'd0, 32'hCE408C20, 2'd0},
    {1'b1, 1'b0, 2'd2, 2'd3, 32'hCE40B800, 2'd0},
    {1'b1, 1'b0, 2'd0, 2'd1, 32'hCE5F9000, 2'd0},
    {1'b1, 1'b1, 2'd0, 2'd0, 32'hCE411000, 2'd1},
    {1'b1, 1'b1, 2'd0, 2'd0, 32'hCE4A7C21, 2'd1},
    {1'b1, 1'b0, 2'd0, 2'd0, 32'hCE40C000, 2'd2},
    {1'b1, 1'b0, 2'd0, 2'd0, 32'hCE600000, 2'd2},
    {1'b1, 1'b0, 2'd0, 2'd0, 32'h00000000, 2'd2}
  };

  function automatic logic [31:0] rr(input logic [31:0] x, input int s);
    logic [63:0] w = {x, x} >> s;
    return w[31:0];
  endfunction

  function automatic logic [31:0] rl(input logic [31:0] x, input int s);
    return rr(x, 32 - s);
  endfunction

  function automatic logic [127:0] mix(input int i, input int k);
    logic [127:0] v;
    for (int j = 0; j < 4; j++)
      v[j*32 +: 32] = (32'h9E3779B9 * (i * 16 + k * 4 + j + 1)) ^ 32'h5A17C3E1;
    return v;
  endfunction

  function automatic logic [127:0] model(input logic [1:0] kind, input logic [1:0] op,
      input logic [1:0] ln, input logic [127:0] d, input logic [127:0] n,
      input logic [127:0] m, input logic [127:0] a);
    logic [31:0] x, y, z, f, s, nd1;
    if (kind == 2'd2) return d;
    if (kind == 2'd1)
      return {rr(rr(n[127:96], 20) + m[127:96] + a[127:96], 25), 96'd0};
    x = d[127:96]; y = d[95:64]; z = d[63:32];
    if (op == 2'd1)      f = (x & y) | (x & z) | (y & z);
    else if (op == 2'd3) f = (x & y) | (~x & z);
    else                 f = x ^ y ^ z;
    s = f + d[31:0] + m[ln*32 +: 32];
    if (op < 2'd2) begin
      s = s + (n[127:96] ^ rr(x, 20));
      nd1 = rr(y, 23);
    end else begin
      s = s + n[127:96];
      s = s ^ rl(s, 9) ^ rl(s, 17);
      nd1 = rr(y, 13);
    end
    return {s, x, nd1, z};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input int i);
    logic [39:0] e = VEC[i];
    use_raw = e[39]; do_ss1 = e[38]; op_code = e[37:36]; lane_sel = e[35:34];
    insn = e[33:2];
    state_in = mix(i, 0); opn_n = mix(i, 1); opn_m = mix(i, 2); opn_a = mix(i, 3);
  endtask

  function automatic logic [127:0] vexp(input int i);
    logic [39:0] e = VEC[i];
    return model(e[1:0], e[37:36], e[35:34], mix(i, 0), mix(i, 1), mix(i, 2), mix(i, 3));
  endfunction

  function automatic string vtag(input int i);
    logic [39:0] e = VEC[i];
    if (e[1:0] == 2'd2) return "R11";
    if (e[39] && e[1:0] == 2'd1) return "R10";
    if (e[39]) return "R9";
    if (e[1:0] == 2'd1) return "R7/R8";
    return "R3/R4/R5/R6/R8";
  endfunction

  task automatic step;
    @(posedge clk); #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step; step; rst = 1'b0;
    // R2 reset state, R1 ready when empty
    chk("R2 reset out_valid", {127'd0, out_valid}, 128'd0);
    chk("R1 idle in_ready", {127'd0, in_ready}, 128'd1);

    // table walk, one operation at a time
    for (int i = 0; i < NV; i++) begin
      load(i); in_valid = 1'b1; out_ready = 1'b1;
      step; in_valid = 1'b0;
      chk({vtag(i), " valid"}, {127'd0, out_valid}, 128'd1);
      chk({vtag(i), " result"}, result, vexp(i));
      chk({vtag(i), " illegal flag"}, {127'd0, illegal}, {127'd0, VEC[i][1:0] == 2'd2});
      step;
      chk("R2 drain", {127'd0, out_valid}, 128'd0);
    end

    // R1 accept and drain in the same cycle, back to back
    load(2); in_valid = 1'b1; out_ready = 1'b1;
    step;
    chk("R1 b2b first", result, vexp(2));
    load(7);
    chk("R1 b2b ready while full", {127'd0, in_ready}, 128'd1);
    step;
    chk("R1 b2b second", result, vexp(7));
    chk("R1 b2b valid", {127'd0, out_valid}, 128'd1);
    in_valid = 1'b0; step;

    // R2 backpressure
    load(3); in_valid = 1'b1; out_ready = 1'b0;
    step;
    load(9);
    chk("R1 ready low when stalled", {127'd0, in_ready}, 128'd0);
    step; step;
    chk("R2 hold valid", {127'd0, out_valid}, 128'd1);
    chk("R2 hold result", result, vexp(3));
    in_valid = 1'b0; out_ready = 1'b1;
    step;
    chk("R2 release", {127'd0, out_valid}, 128'd0);

    // R7 hand value: n3=0, m3=1, a3=0 -> 1 rotated right by 25 = 0x80
    use_raw = 1'b0; do_ss1 = 1'b1; state_in = '1;
    opn_n = 128'h0000_0000_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF;
    opn_m = {32'd1, 96'd7}; opn_a = {32'd0, 96'd3};
    in_valid = 1'b1; step; in_valid = 1'b0;
    chk("R7 hand SS1", result, {32'h00000080, 96'd0});
    step;

    // R5 hand value: d=0, m=0, n3=1, TT2A -> 0x00020201
    do_ss1 = 1'b0; op_code = 2'd2; lane_sel = 2'd0; state_in = '0;
    opn_n = {32'd1, 96'd0}; opn_m = '0;
    in_valid = 1'b1; step; in_valid = 1'b0;
    chk("R5 hand TT2A", result, {32'h00020201, 96'd0});
    step;

    // R12 no carry between lanes: d0=FFFFFFFF, d1=5, m lane 0 = 1
    op_code = 2'd0; lane_sel = 2'd0;
    state_in = {32'd0, 32'd0, 32'd5, 32'hFFFFFFFF};
    opn_n = '0; opn_m = {32'd9, 32'd9, 32'd9, 32'd1};
    in_valid = 1'b1; step; in_valid = 1'b0;
    chk("R12 lane wrap", result, {32'd5, 32'd0, 32'd0, 32'd5});
    step;

    // R2 synchronous reset clears a pending result
    load(1); in_valid = 1'b1; out_ready = 1'b0;
    step; in_valid = 1'b0;
    chk("R2 pending before reset", {127'd0, out_valid}, 128'd1);
    rst = 1'b1; step; rst = 1'b0;
    chk("R2 reset clears valid", {127'd0, out_valid}, 128'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule